// File: doc/BRIEF.md
# Coincident-Selection Static RAM

This block is a small static RAM. Its storage is a square grid of one-bit cells rather than a flat list of words. The address is split into two fields. The upper field drives a row decoder and the lower field drives a column decoder, and each decoder raises exactly one line. A cell takes part in an access only where its row line and its column line are both high. The column decoder is gated by chip select, so when the chip is not selected no cell is touched.

Reads are combinational from the registered cells. The outputs of all selected cells are ORed per data bit, then pass through an output stage that is enabled only during a read. Writes happen on the rising clock edge when chip select and write are both high.

The default build is 16 words of 1 bit on a 4x4 grid. Setting the word width to 2 keeps the same 4x4 grid but gives 8 words of 2 bits. In that build each column line covers a pair of adjacent cells, and the lower cell of the pair carries data bit 0.

Top module: `csram_array`

## Requirements
- R1: While `rst_n` is low, every cell clears to 0. After reset is released, a read of any address returns 0.
- R2: The row decoder drives exactly one of its lines at all times, chosen by the upper address field (`addr[3:2]` in the 16x1 build, `addr[2:1]` in the 8x2 build).
- R3: When `cs` is 0 every column line is 0. When `cs` is 1 exactly one column line is high, chosen by the lower address field (`addr[1:0]` in 16x1, `addr[0]` in 8x2).
- R4: Cells are numbered row-major with 4 cells per row. An access with `cs`=1 selects exactly the cells of the addressed word, and in 16x1 address 4'b1001 selects cell 9. Every address holds its own independent value.
- R5: When `cs`=1 and `we`=0, `dout_en` is 1 and `dout` equals the stored word in the same cycle. Repeated reads do not alter the stored contents.
- R6: On a rising edge with `cs`=1 and `we`=1, `din` is stored into the addressed word only. All other addresses keep their values.
- R7: `dout` is all zeros and `dout_en` is 0 whenever `cs` is 0 or `we` is 1.
- R8: A write attempt with `cs`=0 changes no cell.
- R9: In the 8x2 build, address 3'b011 selects cells 6 and 7, with cell 6 driving data bit 0 and cell 7 driving data bit 1. All 8 two-bit words are independently writable and readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes occur on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears all cells |
| addr | input | ADDR_W (4 by default) | Word address: row field on top, column field below |
| cs | input | 1 | Chip select; enables the column decoder |
| we | input | 1 | 1 = write, 0 = read |
| din | input | DATA_W (1 by default) | Write data |
| dout | output | DATA_W (1 by default) | Read data; zero when the output stage is off |
| dout_en | output | 1 | Output-stage enable; high during a read |

## Verification
Three kinds of address pattern are used on both builds.

- A fixed table of values across all addresses shows that storage and readback work. A second pass with the complement of the table catches cells stuck at a value.
- A walking-one sweep writes a single 1 and reads back every address. This separates row-decode faults from column-decode faults, because a swapped or shorted line lights up the wrong neighbour. The sweep also confirms that address 9 alone holds the 1.
- Write attempts with chip select low are compared against the previous contents. This distinguishes a column decoder correctly gated by chip select from one that ignores it.

// File: rtl/csram_pkg.sv
`timescale 1ns/1ps
package csram_pkg;

  // Number of address bits that feed the column decoder.
  function automatic int col_bits(input int grid_bits, input int data_w);
    return grid_bits - $clog2(data_w);
  endfunction

  // Flat cell index (row-major) of data bit b of word at address a.
  function automatic int cell_of(input int a, input int grid_bits,
                                 input int data_w, input int b);
    int cb;
    int row;
    int col;
    cb  = col_bits(grid_bits, data_w);
    row = a >> cb;
    col = a & ((1 << cb) - 1);
    return row * (1 << grid_bits) + col * data_w + b;
  endfunction

endpackage

// File: rtl/csram_decoder.sv
`timescale 1ns/1ps
module csram_decoder #(
  parameter int IN_W = 2,
  localparam int OUT_N = 1 << IN_W
) (
  input  logic             en,
  input  logic [IN_W-1:0]  code,
  output logic [OUT_N-1:0] lines
);
  always_comb begin
    lines = '0;
    if (en) lines[code] = 1'b1;
  end
endmodule

// File: rtl/csram_cell.sv
`timescale 1ns/1ps
module csram_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic row_sel,
  input  logic col_sel,
  input  logic wr,
  input  logic d,
  output logic sel,
  output logic rd
);
  logic q;
  assign sel = row_sel & col_sel;
  assign rd  = sel & q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         q <= 1'b0;
    else if (wr && sel) q <= d;
  end
endmodule

// File: rtl/csram_grid.sv
`timescale 1ns/1ps
module csram_grid #(
  parameter int GRID_BITS = 2,
  parameter int DATA_W    = 1,
  localparam int SIDE   = 1 << GRID_BITS,
  localparam int NLINES = SIDE / DATA_W,
  localparam int NCELL  = SIDE * SIDE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SIDE-1:0]   row_line,
  input  logic [NLINES-1:0] col_line,
  input  logic              wr,
  input  logic [DATA_W-1:0] din,
  output logic [NCELL-1:0]  cell_sel,
  output logic [DATA_W-1:0] rd_bits
);
  logic [NCELL-1:0] cell_rd;

  for (genvar r = 0; r < SIDE; r++) begin : g_row
    for (genvar k = 0; k < SIDE; k++) begin : g_col
      localparam int LINE = k / DATA_W;
      localparam int B    = k % DATA_W;
      csram_cell u_cell (
        .clk    (clk),
        .rst_n  (rst_n),
        .row_sel(row_line[r]),
        .col_sel(col_line[LINE]),
        .wr     (wr),
        .d      (din[B]),
        .sel    (cell_sel[r*SIDE+k]),
        .rd     (cell_rd[r*SIDE+k])
      );
    end
  end

  // OR of every cell output per data bit
  always_comb begin
    rd_bits = '0;
    for (int i = 0; i < NCELL; i++)
      rd_bits[i % DATA_W] = rd_bits[i % DATA_W] | cell_rd[i];
  end
endmodule

// File: rtl/csram_array.sv
`timescale 1ns/1ps
module csram_array #(
  parameter int GRID_BITS = 2,
  parameter int DATA_W    = 1,
  localparam int COL_W  = csram_pkg::col_bits(GRID_BITS, DATA_W),
  localparam int ADDR_W = GRID_BITS + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cs,
  input  logic              we,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  localparam int SIDE   = 1 << GRID_BITS;
  localparam int NLINES = 1 << COL_W;
  localparam int NCELL  = SIDE * SIDE;

  logic [SIDE-1:0]   row_line;
  logic [NLINES-1:0] col_line;
  logic [NCELL-1:0]  cell_sel;
  logic [DATA_W-1:0] rd_bits;
  logic              wr_strobe;

  assign wr_strobe = cs & we;

  csram_decoder #(.IN_W(GRID_BITS)) u_rowdec (
    .en   (1'b1),
    .code (addr[ADDR_W-1:COL_W]),
    .lines(row_line)
  );

  csram_decoder #(.IN_W(COL_W)) u_coldec (
    .en   (cs),
    .code (addr[COL_W-1:0]),
    .lines(col_line)
  );

  csram_grid #(.GRID_BITS(GRID_BITS), .DATA_W(DATA_W)) u_grid (
    .clk     (clk),
    .rst_n   (rst_n),
    .row_line(row_line),
    .col_line(col_line),
    .wr      (wr_strobe),
    .din     (din),
    .cell_sel(cell_sel),
    .rd_bits (rd_bits)
  );

  // output stage: enabled only on reads
  assign dout_en = cs & ~we;
  assign dout    = dout_en ? rd_bits : '0;
endmodule

// File: rtl/csram_check.sv
`timescale 1ns/1ps
module csram_check #(
  parameter int GRID_BITS = 2,
  parameter int DATA_W    = 1,
  localparam int COL_W  = csram_pkg::col_bits(GRID_BITS, DATA_W),
  localparam int ADDR_W = GRID_BITS + COL_W,
  localparam int SIDE   = 1 << GRID_BITS,
  localparam int NLINES = 1 << COL_W,
  localparam int NCELL  = SIDE * SIDE
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              cs,
  input logic              we,
  input logic [DATA_W-1:0] din,
  input logic [DATA_W-1:0] dout,
  input logic              dout_en,
  input logic [SIDE-1:0]   row_line,
  input logic [NLINES-1:0] col_line,
  input logic [NCELL-1:0]  cell_sel
);
  import csram_pkg::*;

  p_row_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(row_line) == 1);

  p_col_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |-> col_line == '0);

  p_col_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cs |-> $countones(col_line) == 1);

  p_sel_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cell_sel) == (cs ? DATA_W : 0));

  p_sel_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cs |-> cell_sel[cell_of(int'(addr), GRID_BITS, DATA_W, 0)]);

  // R9: top bit of the word lands on the adjacent cell
  p_sel_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cs |-> cell_sel[cell_of(int'(addr), GRID_BITS, DATA_W, DATA_W-1)]);

  p_read_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && !we && $past(cs && !we) && $stable(addr)) |-> $stable(dout));

  p_write_back_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && !we && $past(cs && we) && $stable(addr)) |-> dout == $past(din));

  p_quiet_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs || we) |-> (dout == '0 && !dout_en));

  p_read_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && !we) |-> dout_en);
endmodule

bind csram_array csram_check #(.GRID_BITS(GRID_BITS), .DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .addr    (addr),
  .cs      (cs),
  .we      (we),
  .din     (din),
  .dout    (dout),
  .dout_en (dout_en),
  .row_line(row_line),
  .col_line(col_line),
  .cell_sel(cell_sel)
);

// File: tb/sim_csram_array.sv
`timescale 1ns/1ps
module sim_csram_array;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  // 16x1 build
  logic [3:0] a0 = '0;
  logic       cs0 = 1'b0, we0 = 1'b0;
  logic [0:0] d0 = '0;
  logic [0:0] q0;
  logic       oe0;
  // 8x2 build
  logic [2:0] a1 = '0;
  logic       cs1 = 1'b0, we1 = 1'b0;
  logic [1:0] d1 = '0;
  logic [1:0] q1;
  logic       oe1;

  csram_array u0 (.clk(clk), .rst_n(rst_n), .addr(a0), .cs(cs0), .we(we0),
                  .din(d0), .dout(q0), .dout_en(oe0));
  csram_array #(.GRID_BITS(2), .DATA_W(2)) u1 (
                  .clk(clk), .rst_n(rst_n), .addr(a1), .cs(cs1), .we(we1),
                  .din(d1), .dout(q1), .dout_en(oe1));

  localparam logic VEC0 [16] = '{1'b1,1'b0,1'b0,1'b1, 1'b1,1'b1,1'b0,1'b0,
                                  1'b0,1'b1,1'b1,1'b0, 1'b1,1'b0,1'b1,1'b1};
  localparam logic [1:0] VEC1 [8] = '{2'd1,2'd2,2'd3,2'd0,2'd2,2'd3,2'd1,2'd0};

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr0(input int a, input logic d, input logic sel);
    @(negedge clk);
    a0 = a[3:0]; d0 = d; cs0 = sel; we0 = 1'b1;
    #2;
    chk(q0 == 1'b0 && !oe0, "R7 output off during write/deselect", {q0, oe0}, 0);
    @(negedge clk);
    cs0 = 1'b0; we0 = 1'b0;
  endtask

  task automatic rd0(input int a, input logic exp, input string req);
    @(negedge clk);
    a0 = a[3:0]; cs0 = 1'b1; we0 = 1'b0;
    #2;
    chk(oe0 == 1'b1 && q0 == exp, req, int'(q0), int'(exp));
  endtask

  task automatic wr1(input int a, input logic [1:0] d);
    @(negedge clk);
    a1 = a[2:0]; d1 = d; cs1 = 1'b1; we1 = 1'b1;
    @(negedge clk);
    cs1 = 1'b0; we1 = 1'b0;
  endtask

  task automatic rd1(input int a, input logic [1:0] exp, input string req);
    @(negedge clk);
    a1 = a[2:0]; cs1 = 1'b1; we1 = 1'b0;
    #2;
    chk(oe1 == 1'b1 && q1 == exp, req, int'(q1), int'(exp));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cs0 = 1'b0; we0 = 1'b0; cs1 = 1'b0; we1 = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: reset state
    for (int a = 0; a < 16; a++) rd0(a, 1'b0, "R1 reset clears 16x1");
    for (int a = 0; a < 8; a++)  rd1(a, 2'd0, "R1 reset clears 8x2");

    // R6/R5: table pattern, then its complement
    for (int p = 0; p < 2; p++) begin
      for (int a = 0; a < 16; a++) wr0(a, VEC0[a] ^ p[0], 1'b1);
      for (int a = 0; a < 16; a++) rd0(a, VEC0[a] ^ p[0], "R6 pattern readback");
      for (int a = 0; a < 16; a++) rd0(a, VEC0[a] ^ p[0], "R5 reread unchanged");
    end

    // R8: writes with cs low change nothing (stored = complement pattern)
    for (int a = 0; a < 16; a++) wr0(a, VEC0[a], 1'b0);
    for (int a = 0; a < 16; a++) rd0(a, ~VEC0[a], "R8 deselected write ignored");

    // R7: deselected read keeps output off
    @(negedge clk); a0 = 4'd0; cs0 = 1'b0; we0 = 1'b0; #2;
    chk(q0 == 1'b0 && !oe0, "R7 output off when deselected", {q0, oe0}, 0);

    // R4: walking one; address 9 maps to its own cell
    for (int a = 0; a < 16; a++) wr0(a, 1'b0, 1'b1);
    for (int w = 0; w < 16; w++) begin
      wr0(w, 1'b1, 1'b1);
      for (int a = 0; a < 16; a++)
        rd0(a, (a == w), (w == 9) ? "R4 cell 9 only" : "R4 walking one");
      wr0(w, 1'b0, 1'b1);
    end

    // R9: 8x2 build, two passes
    for (int p = 0; p < 2; p++) begin
      for (int a = 0; a < 8; a++) wr1(a, VEC1[a] ^ {p[0], p[0]});
      for (int a = 0; a < 8; a++) rd1(a, VEC1[a] ^ {p[0], p[0]}, "R9 pair word readback");
    end
    // R9: address 3 bit 0 and bit 1 are separate cells
    for (int a = 0; a < 8; a++) wr1(a, 2'd0);
    wr1(3, 2'b01);
    rd1(3, 2'b01, "R9 addr3 bit0");
    rd1(2, 2'b00, "R9 neighbour untouched");
    wr1(3, 2'b10);
    rd1(3, 2'b10, "R9 addr3 bit1");
    rd1(4, 2'b00, "R9 neighbour untouched");

    // R1: reset mid-run clears contents
    wr0(5, 1'b1, 1'b1);
    do_reset();
    rd0(5, 1'b0, "R1 reset after writes");
    rd1(3, 2'd0, "R1 reset after writes 8x2");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule